// File: doc/BRIEF.md
# Presettable Counter with Terminal Reload

This block is a synchronous binary up-counter of parameterised width (eight bits by default). It can be preset from a parallel word, can hold its value or advance it, and can be cleared at any moment by an asynchronous, active-high clear. An active-low terminal flag marks the state in which every count bit is one.

When the reload-on-terminal control is high, the terminal state feeds back inside the block. The next counting edge then copies the preset word into the count instead of wrapping to zero. The counter becomes a programmable divider: a preset of 2^WIDTH − N gives a period of N clocks, for any N from 2 to 2^WIDTH. A registered copy of the terminal flag serves as the divider output. It is a clean, active-high pulse one clock wide.

Top module: `counter_preset_div`

## Requirements
- R1: While `rst_async` is high, `count` is 0, `term_n` is 1 and `div_out` is 0. This takes effect at once, with no clock edge, and overrides every other input.
- R2: When `load_n` is 0, a rising clock edge copies `preset` into `count`, whatever the values of `cnt_en_n` and `reload_on_term`.
- R3: With `load_n`=1, `cnt_en_n`=0 and `reload_on_term`=0, each rising edge adds one to `count`. All ones wraps to 0.
- R4: With `load_n`=1 and `cnt_en_n`=1, `count` keeps its value across edges. This holds even in the all-ones state with `reload_on_term`=1.
- R5: `term_n` is 0 exactly when every bit of `count` is 1, and 1 otherwise.
- R6: With `load_n`=1, `cnt_en_n`=0, `reload_on_term`=1 and `count` all ones, the next rising edge copies `preset` into `count` instead of wrapping.
- R7: `div_out` is 1 during exactly the clock cycle that follows a cycle in which `term_n` was 0 at the rising edge; otherwise it is 0.
- R8: When the counter runs in reload mode with preset 2^WIDTH − N, for N from 2 to 2^WIDTH, `div_out` pulses once every N clocks. For WIDTH=8, N=113 needs preset 0x8F, and N=256 needs preset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_async | input | 1 | Asynchronous clear, active high |
| load_n | input | 1 | Parallel load enable, active low |
| cnt_en_n | input | 1 | Count enable, active low (high holds) |
| reload_on_term | input | 1 | Reload the preset at the terminal state, active high |
| preset | input | WIDTH | Parallel preset word |
| count | output | WIDTH | Counter state |
| term_n | output | 1 | Terminal flag, low while count is all ones |
| div_out | output | 1 | Registered divider pulse, active high |

## Verification
The bench sweeps every divide ratio from 2 to 256 and measures the gap between divider pulses. An off-by-one reload, such as reloading one edge late or reloading the preset plus one, shows up as a period of N+1 or N−1. A pulse that stays high shows up as a period of one. Other checks cover the corner cases:
- Load must win over hold and over reload; a wrong priority leaves the old count in place.
- Hold must beat reload at all ones; otherwise the count jumps to the preset.
- A plain count must wrap from 255 to 0.
- The clear is raised between edges. A synchronous clear would leave the count nonzero until the next edge.

// File: rtl/cnt_pkg.sv
// Package: shared types for the presettable counter.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package cnt_pkg;

    // Operation selected for the next clock edge.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_INC  = 2'd1,
        OP_LOAD = 2'd2
    } cnt_op_e;

    // Priority decode: load beats hold, hold beats reload and increment.
    function automatic cnt_op_e pick_op(
        input logic load_n,
        input logic cnt_en_n,
        input logic reload_on_term,
        input logic at_term
    );
        if (!load_n)
            return OP_LOAD;
        else if (cnt_en_n)
            return OP_HOLD;
        else if (reload_on_term && at_term)
            return OP_LOAD;
        else
            return OP_INC;
    endfunction

endpackage

// File: rtl/cnt_op_decode.sv
// Module: cnt_op_decode
// Chooses the counter operation for the coming edge from the control
// inputs and the registered terminal state. Purely combinational.
// Assumes at_term comes from registered state, so there is no loop.
module cnt_op_decode
    import cnt_pkg::*;
(
    input  logic    load_n,
    input  logic    cnt_en_n,
    input  logic    reload_on_term,
    input  logic    at_term,
    output cnt_op_e op
);

    // Priority decode of the three controls plus internal feedback.
    always_comb begin
        op = pick_op(load_n, cnt_en_n, reload_on_term, at_term);
    end

endmodule

// File: rtl/cnt_state_reg.sv
// Module: cnt_state_reg
// Holds the count and applies the selected operation at each rising
// edge. Cleared asynchronously by an active-high clear.
// Assumes op is settled before the edge.
module cnt_state_reg
    import cnt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_async,
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] count
);

    logic [WIDTH-1:0] count_nxt;

    // Next-state selection for the count register.
    always_comb begin
        unique case (op)
            OP_LOAD: count_nxt = preset;
            OP_INC:  count_nxt = count + WIDTH'(1);
            default: count_nxt = count;
        endcase
    end

    // Count register with asynchronous clear.
    always_ff @(posedge clk or posedge rst_async) begin
        if (rst_async)
            count <= '0;
        else
            count <= count_nxt;
    end

endmodule

// File: rtl/cnt_term_pulse.sv
// Module: cnt_term_pulse
// Detects the all-ones state and registers it into a one-clock divider
// pulse. Cleared asynchronously together with the count.
// Assumes count is a register output.
module cnt_term_pulse #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_async,
    input  logic [WIDTH-1:0] count,
    output logic             at_term,
    output logic             div_out
);

    // All-ones detection from registered state.
    always_comb begin
        at_term = &count;
    end

    // Registered copy of the terminal state, used as the divider output.
    always_ff @(posedge clk or posedge rst_async) begin
        if (rst_async)
            div_out <= 1'b0;
        else
            div_out <= at_term;
    end

endmodule

// File: rtl/counter_preset_div.sv
// Module: counter_preset_div
// Presettable synchronous up-counter with an active-low terminal flag
// and internal reload at the terminal state, which makes it a divide-by-N
// programmable divider (preset = 2^WIDTH - N, N = 2..2^WIDTH).
// Assumes a single clock domain. rst_async may change at any time.
module counter_preset_div #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_async,
    input  logic             load_n,
    input  logic             cnt_en_n,
    input  logic             reload_on_term,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] count,
    output logic             term_n,
    output logic             div_out
);

    cnt_pkg::cnt_op_e op;
    logic             at_term;

    cnt_op_decode u_decode (
        .load_n         (load_n),
        .cnt_en_n       (cnt_en_n),
        .reload_on_term (reload_on_term),
        .at_term        (at_term),
        .op             (op)
    );

    cnt_state_reg #(.WIDTH(WIDTH)) u_state (
        .clk       (clk),
        .rst_async (rst_async),
        .op        (op),
        .preset    (preset),
        .count     (count)
    );

    cnt_term_pulse #(.WIDTH(WIDTH)) u_term (
        .clk       (clk),
        .rst_async (rst_async),
        .count     (count),
        .at_term   (at_term),
        .div_out   (div_out)
    );

    // Active-low terminal flag at the port.
    always_comb begin
        term_n = ~at_term;
    end

endmodule

// File: rtl/counter_preset_div_chk.sv
// Module: counter_preset_div_chk
// Assertion checker for counter_preset_div, attached by bind.
// Observes the ports only.
module counter_preset_div_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_async,
    input logic             load_n,
    input logic             cnt_en_n,
    input logic             reload_on_term,
    input logic [WIDTH-1:0] preset,
    input logic [WIDTH-1:0] count,
    input logic             term_n,
    input logic             div_out
);

    // R1: clear state is seen at every edge while clear is high
    a_r1_clear_state: assert property (@(posedge clk)
        rst_async |-> (count == '0 && term_n && !div_out));

    // R2: a load edge copies the preset word
    a_r2_load: assert property (@(posedge clk) disable iff (rst_async)
        !load_n |=> count == $past(preset));

    // R3: plain counting adds one, with wrap
    a_r3_increment: assert property (@(posedge clk) disable iff (rst_async)
        (load_n && !cnt_en_n && !reload_on_term) |=> count == WIDTH'($past(count) + WIDTH'(1)));

    // R4: disabled count holds
    a_r4_hold: assert property (@(posedge clk) disable iff (rst_async)
        (load_n && cnt_en_n) |=> $stable(count));

    // R6: reload at the terminal state
    a_r6_reload: assert property (@(posedge clk) disable iff (rst_async)
        (load_n && !cnt_en_n && reload_on_term && !term_n) |=> count == $past(preset));

    // R7: divider pulse follows a terminal cycle
    a_r7_pulse: assert property (@(posedge clk) disable iff (rst_async)
        !term_n |=> div_out);

endmodule

bind counter_preset_div counter_preset_div_chk #(.WIDTH(WIDTH)) u_chk (
    .clk            (clk),
    .rst_async      (rst_async),
    .load_n         (load_n),
    .cnt_en_n       (cnt_en_n),
    .reload_on_term (reload_on_term),
    .preset         (preset),
    .count          (count),
    .term_n         (term_n),
    .div_out        (div_out)
);

// File: tb/test_counter_preset_div.sv
// Bench for counter_preset_div: directed checks plus a sweep over
// every divide ratio. Inputs change and outputs are sampled on the
// falling clock edge.
module test_counter_preset_div;

    localparam int W = 8;
    localparam int M = 1 << W;

    logic         clk = 1'b0;
    logic         rst_async = 1'b1;
    logic         load_n = 1'b1;
    logic         cnt_en_n = 1'b1;
    logic         reload_on_term = 1'b0;
    logic [W-1:0] preset = '0;
    logic [W-1:0] count;
    logic         term_n;
    logic         div_out;

    int n_chk = 0;
    int n_err = 0;

    counter_preset_div #(.WIDTH(W)) i_counter_preset_div (
        .clk            (clk),
        .rst_async      (rst_async),
        .load_n         (load_n),
        .cnt_en_n       (cnt_en_n),
        .reload_on_term (reload_on_term),
        .preset         (preset),
        .count          (count),
        .term_n         (term_n),
        .div_out        (div_out)
    );

    // 50 MHz clock
    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_load(input logic [W-1:0] v);
        preset = v;
        load_n = 1'b0;
        step();
        load_n = 1'b1;
    endtask

    initial begin
        #(190000 * 20);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int exp_cnt;
        step();
        // R1: reset state
        chk("R1 count in reset", int'(count), 0);
        chk("R1 term_n in reset", int'(term_n), 1);
        chk("R1 div_out in reset", int'(div_out), 0);
        rst_async = 1'b0;
        step();

        // R2: load wins over count enable and reload
        cnt_en_n = 1'b0; reload_on_term = 1'b1;
        do_load(8'hA5);
        chk("R2 load with count enabled", int'(count), 'hA5);
        cnt_en_n = 1'b1;
        do_load(8'h3C);
        chk("R2 load while hold", int'(count), 'h3C);

        // R3: counting with wrap from 255 to 0
        reload_on_term = 1'b0; cnt_en_n = 1'b1;
        do_load(8'd250);
        cnt_en_n = 1'b0;
        exp_cnt = 250;
        for (int i = 0; i < 10; i++) begin
            step();
            exp_cnt = (exp_cnt + 1) % M;
            chk("R3 increment/wrap", int'(count), exp_cnt);
        end

        // R5: terminal flag at 254 and 255
        cnt_en_n = 1'b1;
        do_load(8'd254);
        chk("R5 term_n at 254", int'(term_n), 1);
        do_load(8'd255);
        chk("R5 term_n at 255", int'(term_n), 0);

        // R4: hold at all ones with reload high
        reload_on_term = 1'b1; preset = 8'h10;
        step(); step();
        chk("R4 hold at all ones", int'(count), 255);

        // R6/R7: reload at terminal, pulse one cycle wide
        preset = 8'h8F;
        cnt_en_n = 1'b0;
        step();
        chk("R6 reload at terminal", int'(count), 'h8F);
        chk("R7 div_out after terminal", int'(div_out), 1);
        step();
        chk("R7 div_out drops", int'(div_out), 0);
        chk("R3 counts after reload", int'(count), 'h90);

        // R1: asynchronous clear between edges
        #5 rst_async = 1'b1;
        #1;
        chk("R1 async count", int'(count), 0);
        chk("R1 async term_n", int'(term_n), 1);
        chk("R1 async div_out", int'(div_out), 0);
        step();
        rst_async = 1'b0;
        step();

        // R8: every divide ratio from 2 to 256
        for (int n = 2; n <= M; n++) begin
            int gap;
            int guard;
            cnt_en_n = 1'b1; reload_on_term = 1'b1;
            do_load(W'(M - n));
            cnt_en_n = 1'b0;
            guard = 0;
            while (div_out !== 1'b1 && guard < 2 * M) begin
                step(); guard++;
            end
            gap = 0;
            do begin
                step(); gap++;
            end while (div_out !== 1'b1 && gap < 2 * M);
            chk($sformatf("R8 period for N=%0d", n), gap, n);
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule